// File: doc/BRIEF.md
# Windowed Clock Frequency Monitor

This block watches a clock whose frequency cannot be trusted on its own, such as a PLL output. It measures that clock against a trusted reference clock, such as an internal RC oscillator, and reports when the frequency leaves a programmable band. The reference clock sets a measurement window of a fixed number of its own cycles. During each window the block counts rising edges of the monitored clock. It then compares the count with an upper and a lower threshold. The monitored clock is only ever measured and never drives the window timing.

Each threshold is in units of one sixty-fourth of the reference frequency, so the limits are f_ref × threshold / 64. Window boundaries pass into the monitored domain as a toggle through a synchronizer. The finished count comes back under a toggle handshake, and the held count is read only after the handshake edge has been synchronized. If the monitored clock stops, the handshake never returns. After two windows without an answer, the block reports a count of zero, which shows up as a low-frequency fault.

Top module: `clk_freq_window_mon`

## Requirements
- R1: While `en` is high, a measurement window lasts 64 reference cycles. The first window starts in the cycle in which `en` is first sampled high. Each window result is the number of monitored rising edges in one window, ±1 for synchronizer phase.
- R2: A window result strictly greater than `thr_hi` (12-bit unsigned) sets `flag_hi`.
- R3: A window result strictly less than `thr_lo` (12-bit unsigned) sets `flag_lo`. A result equal to a threshold sets neither flag.
- R4: Both flags are sticky. A one-cycle `clr` pulse clears both flags in the next cycle, unless a new violation is reported in that same cycle, in which case that flag is set.
- R5: The first window result after `en` rises is discarded and can set no flag.
- R6: If no result returns from the monitored domain for two consecutive windows, a result of zero is evaluated. This sets `flag_lo` if `thr_lo` is nonzero and sets nothing if `thr_lo` is zero.
- R7: The thresholds are sampled at a window boundary. They apply to the result of the window that starts at that boundary, so a change made mid-window affects the result reported two boundaries later.
- R8: While `en` is low, no windows run and neither flag is set. The flags keep their values, and `clr` still clears them.
- R9: The edge count saturates at 4095 instead of wrapping.
- R10: Synchronous active-high `rst` clears both flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Trusted reference clock; defines the window |
| clk_mon | input | 1 | Clock under observation |
| rst | input | 1 | Synchronous active-high reset, reference domain |
| en | input | 1 | Run measurement windows while high |
| thr_hi | input | 12 | Upper count threshold (per 64 reference cycles) |
| thr_lo | input | 12 | Lower count threshold (per 64 reference cycles) |
| clr | input | 1 | One-cycle pulse clearing both flags |
| flag_hi | output | 1 | Sticky over-frequency flag |
| flag_lo | output | 1 | Sticky under-frequency or stopped-clock flag |

## Verification
A result for a window is due a few cycles after the boundary that closes the window. The delay is two monitored cycles of synchronization, two reference cycles for the returning toggle, and two register stages to the flag. The bench drives `en` on a falling edge and counts reference cycles from that point. Every flag check is therefore sampled in the middle of a window, 32 cycles after a boundary, which is well clear of any result in flight. A threshold change lands mid-window and is checked at the next two mid-window points to separate old and new thresholds. Timeout and saturation cases are checked several windows after the stimulus.

// File: rtl/fmon_pkg.sv
package fmon_pkg;
  localparam int unsigned DEF_CNT_W      = 12;
  localparam int unsigned DEF_WIN_LOG2   = 6;
  localparam int unsigned DEF_SYNC       = 2;
  localparam int unsigned DEF_MISS_LIMIT = 2;

  typedef struct packed {
    logic hi;
    logic lo;
  } fault_t;
endpackage

// File: rtl/fmon_sync.sv
module fmon_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[0] <= '0;
        else     stg[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= '0;
        else     stg[i] <= stg[i-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/fmon_edge_count.sv
module fmon_edge_count #(
  parameter int unsigned CNT_W = 12,
  parameter int unsigned SYNC  = 2
) (
  input  logic             clk_mon,
  input  logic             rst_src,
  input  logic             win_tgl,
  output logic [CNT_W-1:0] cap_cnt,
  output logic             ack_tgl
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             rst_m;
  logic             win_s;
  logic             win_d;
  logic             win_ev;
  logic [CNT_W-1:0] cnt;

  fmon_sync #(.W(1), .STAGES(SYNC)) u_rst_sync (
    .clk(clk_mon), .rst(1'b0), .d(rst_src), .q(rst_m)
  );

  fmon_sync #(.W(1), .STAGES(SYNC)) u_win_sync (
    .clk(clk_mon), .rst(rst_m), .d(win_tgl), .q(win_s)
  );

  assign win_ev = win_s ^ win_d;

  always_ff @(posedge clk_mon) begin
    if (rst_m) begin
      win_d   <= 1'b0;
      cnt     <= '0;
      cap_cnt <= '0;
      ack_tgl <= 1'b0;
    end else begin
      win_d <= win_s;
      if (win_ev) begin
        cap_cnt <= cnt;
        cnt     <= CNT_W'(1);
        ack_tgl <= ~ack_tgl;
      end else if (cnt != CNT_MAX) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R9: a full counter stays full until the next window edge
  assert_cnt_hold_max_R9: assert property (@(posedge clk_mon) disable iff (rst_m)
    (!win_ev && cnt == CNT_MAX) |=> cnt == CNT_MAX);

  // R1: held count only moves together with the handshake toggle
  assert_cap_hold_R1: assert property (@(posedge clk_mon) disable iff (rst_m)
    !$stable(cap_cnt) |-> !$stable(ack_tgl));
endmodule

// File: rtl/fmon_ref_ctrl.sv
module fmon_ref_ctrl #(
  parameter int unsigned CNT_W      = 12,
  parameter int unsigned WIN_LOG2   = 6,
  parameter int unsigned SYNC       = 2,
  parameter int unsigned MISS_LIMIT = 2
) (
  input  logic             clk_ref,
  input  logic             rst,
  input  logic             en,
  input  logic [CNT_W-1:0] thr_hi,
  input  logic [CNT_W-1:0] thr_lo,
  input  logic [CNT_W-1:0] cap_cnt,
  input  logic             ack_tgl,
  output logic             win_tgl,
  output logic             res_vld,
  output logic [CNT_W-1:0] res_cnt,
  output logic [CNT_W-1:0] res_hi,
  output logic [CNT_W-1:0] res_lo
);
  localparam int unsigned        MISS_W    = $clog2(MISS_LIMIT + 1);
  localparam logic [MISS_W-1:0]  MISS_LAST = MISS_W'(MISS_LIMIT - 1);
  localparam logic [WIN_LOG2-1:0] TMR_LAST = '1;

  logic                ack_s, ack_d, ack_ev;
  logic                en_q, start, running, bnd;
  logic [WIN_LOG2-1:0] tmr;
  logic                discard, got_ack;
  logic [MISS_W-1:0]   miss;
  logic [CNT_W-1:0]    win_hi, win_lo, ev_hi, ev_lo;

  fmon_sync #(.W(1), .STAGES(SYNC)) u_ack_sync (
    .clk(clk_ref), .rst(rst), .d(ack_tgl), .q(ack_s)
  );

  assign ack_ev  = ack_s ^ ack_d;
  assign start   = en & ~en_q;
  assign running = en & en_q;
  assign bnd     = running && (tmr == TMR_LAST);

  always_ff @(posedge clk_ref) begin
    if (rst) begin
      ack_d   <= 1'b0;
      en_q    <= 1'b0;
      tmr     <= '0;
      discard <= 1'b1;
      got_ack <= 1'b1;
      miss    <= '0;
      win_tgl <= 1'b0;
      win_hi  <= '0;
      win_lo  <= '0;
      ev_hi   <= '0;
      ev_lo   <= '0;
      res_vld <= 1'b0;
      res_cnt <= '0;
      res_hi  <= '0;
      res_lo  <= '0;
    end else begin
      ack_d   <= ack_s;
      en_q    <= en;
      res_vld <= 1'b0;
      if (start) begin
        tmr     <= '0;
        discard <= 1'b1;
        got_ack <= 1'b1;
        miss    <= '0;
        win_hi  <= thr_hi;
        win_lo  <= thr_lo;
      end else if (running) begin
        tmr <= tmr + 1'b1;
        if (ack_ev) begin
          if (discard) begin
            discard <= 1'b0;
          end else begin
            res_vld <= 1'b1;
            res_cnt <= cap_cnt;
            res_hi  <= ev_hi;
            res_lo  <= ev_lo;
          end
        end
        if (bnd) begin
          win_tgl <= ~win_tgl;
          ev_hi   <= win_hi;
          ev_lo   <= win_lo;
          win_hi  <= thr_hi;
          win_lo  <= thr_lo;
          got_ack <= 1'b0;
          if (got_ack || ack_ev) begin
            miss <= '0;
          end else if (miss == MISS_LAST) begin
            miss <= '0;
            if (discard) begin
              discard <= 1'b0;
            end else begin
              res_vld <= 1'b1;
              res_cnt <= '0;
              res_hi  <= ev_hi;
              res_lo  <= ev_lo;
            end
          end else begin
            miss <= miss + 1'b1;
          end
        end else if (ack_ev) begin
          got_ack <= 1'b1;
        end
      end
    end
  end

  // R1: the window toggle moves only at a boundary
  assert_tgl_at_bnd_R1: assert property (@(posedge clk_ref) disable iff (rst)
    !bnd |=> $stable(win_tgl));

  // R7: thresholds in use change only at a boundary
  assert_thr_at_bnd_R7: assert property (@(posedge clk_ref) disable iff (rst)
    !bnd |=> ($stable(ev_hi) && $stable(ev_lo)));

  // R8: no result is produced while disabled
  assert_no_result_idle_R8: assert property (@(posedge clk_ref) disable iff (rst)
    !en |=> !res_vld);

  // R6: missed-answer count never reaches its limit
  assert_miss_bound_R6: assert property (@(posedge clk_ref) disable iff (rst)
    int'(miss) < int'(MISS_LIMIT));
endmodule

// File: rtl/fmon_judge.sv
module fmon_judge
  import fmon_pkg::*;
#(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk_ref,
  input  logic             rst,
  input  logic             en,
  input  logic             clr,
  input  logic             res_vld,
  input  logic [CNT_W-1:0] res_cnt,
  input  logic [CNT_W-1:0] res_hi,
  input  logic [CNT_W-1:0] res_lo,
  output fault_t           flags
);
  fault_t set_now;

  always_comb begin
    set_now.hi = en && res_vld && (res_cnt > res_hi);
    set_now.lo = en && res_vld && (res_cnt < res_lo);
  end

  always_ff @(posedge clk_ref) begin
    if (rst) flags <= '0;
    else     flags <= (flags & ~{2{clr}}) | set_now;
  end

  // R4: a set flag stays set without a clear
  assert_sticky_hi_R4: assert property (@(posedge clk_ref) disable iff (rst)
    (flags.hi && !clr) |=> flags.hi);
  assert_sticky_lo_R4: assert property (@(posedge clk_ref) disable iff (rst)
    (flags.lo && !clr) |=> flags.lo);

  // R8: disabled and not cleared means frozen flags
  assert_hold_idle_R8: assert property (@(posedge clk_ref) disable iff (rst)
    (!en && !clr) |=> $stable(flags));

  // R2: a rising high flag has a result above the threshold behind it
  assert_hi_cause_R2: assert property (@(posedge clk_ref) disable iff (rst)
    $rose(flags.hi) |-> $past(res_vld && (res_cnt > res_hi)));

  // R3: a rising low flag has a result below the threshold behind it
  assert_lo_cause_R3: assert property (@(posedge clk_ref) disable iff (rst)
    $rose(flags.lo) |-> $past(res_vld && (res_cnt < res_lo)));
endmodule

// File: rtl/clk_freq_window_mon.sv
module clk_freq_window_mon
  import fmon_pkg::*;
#(
  parameter int unsigned CNT_W      = DEF_CNT_W,
  parameter int unsigned WIN_LOG2   = DEF_WIN_LOG2,
  parameter int unsigned SYNC       = DEF_SYNC,
  parameter int unsigned MISS_LIMIT = DEF_MISS_LIMIT
) (
  input  logic             clk_ref,
  input  logic             clk_mon,
  input  logic             rst,
  input  logic             en,
  input  logic [CNT_W-1:0] thr_hi,
  input  logic [CNT_W-1:0] thr_lo,
  input  logic             clr,
  output logic             flag_hi,
  output logic             flag_lo
);
  logic             win_tgl;
  logic             ack_tgl;
  logic [CNT_W-1:0] cap_cnt;
  logic             res_vld;
  logic [CNT_W-1:0] res_cnt, res_hi, res_lo;
  fault_t           flags;

  fmon_edge_count #(.CNT_W(CNT_W), .SYNC(SYNC)) u_count (
    .clk_mon (clk_mon),
    .rst_src (rst),
    .win_tgl (win_tgl),
    .cap_cnt (cap_cnt),
    .ack_tgl (ack_tgl)
  );

  fmon_ref_ctrl #(
    .CNT_W(CNT_W), .WIN_LOG2(WIN_LOG2), .SYNC(SYNC), .MISS_LIMIT(MISS_LIMIT)
  ) u_ctrl (
    .clk_ref (clk_ref),
    .rst     (rst),
    .en      (en),
    .thr_hi  (thr_hi),
    .thr_lo  (thr_lo),
    .cap_cnt (cap_cnt),
    .ack_tgl (ack_tgl),
    .win_tgl (win_tgl),
    .res_vld (res_vld),
    .res_cnt (res_cnt),
    .res_hi  (res_hi),
    .res_lo  (res_lo)
  );

  fmon_judge #(.CNT_W(CNT_W)) u_judge (
    .clk_ref (clk_ref),
    .rst     (rst),
    .en      (en),
    .clr     (clr),
    .res_vld (res_vld),
    .res_cnt (res_cnt),
    .res_hi  (res_hi),
    .res_lo  (res_lo),
    .flags   (flags)
  );

  assign flag_hi = flags.hi;
  assign flag_lo = flags.lo;

  // R10: flags are clear right after reset
  assert_reset_clear_R10: assert property (@(posedge clk_ref)
    $past(rst) |-> (!flag_hi && !flag_lo));
endmodule

// File: tb/clk_freq_window_mon_bench.sv
`timescale 1ns/1ps
module clk_freq_window_mon_bench;
  logic        clk_ref = 1'b0;
  logic        clk_mon = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic        clr = 1'b0;
  logic [11:0] thr_hi = '0;
  logic [11:0] thr_lo = '0;
  logic        flag_hi, flag_lo;

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;
  real mon_half = 2.0;
  bit  mon_run = 1'b1;

  clk_freq_window_mon u_clk_freq_window_mon (
    .clk_ref(clk_ref), .clk_mon(clk_mon), .rst(rst), .en(en),
    .thr_hi(thr_hi), .thr_lo(thr_lo), .clr(clr),
    .flag_hi(flag_hi), .flag_lo(flag_lo)
  );

  always #4 clk_ref = ~clk_ref;

  initial begin
    #1;
    forever begin
      #(mon_half);
      if (mon_run) clk_mon = ~clk_mon;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk_ref);
  endtask

  task automatic pulse_clr();
    clr = 1'b1;
    wait_cyc(1);
    clr = 1'b0;
  endtask

  // expected edges per 64 reference cycles (8 ns period)
  function automatic real exp_count(input real half);
    return 256.0 / half;
  endfunction

  function automatic int pick_thr(input real n);
    int t;
    real d;
    do begin
      t = int'($urandom_range(0, 2 * int'(n) + 20));
      d = real'(t) - n;
      if (d < 0.0) d = -d;
    end while (d < 3.0);
    return t;
  endfunction

  initial begin
    void'($urandom(32'd4242));
    wait_cyc(3);
    chk("R10 reset hi", int'(flag_hi), 0);
    chk("R10 reset lo", int'(flag_lo), 0);
    rst = 1'b0;

    // R5 and R1: large stale count on first window is dropped
    mon_half = 2.0; thr_hi = 12'd138; thr_lo = 12'd118;
    wait_cyc(300);
    en = 1'b1;
    wait_cyc(96);
    chk("R5 first window hi", int'(flag_hi), 0);
    chk("R5 first window lo", int'(flag_lo), 0);
    wait_cyc(64);
    chk("R1 in band hi", int'(flag_hi), 0);
    chk("R1 in band lo", int'(flag_lo), 0);

    // R3: count equal to both thresholds raises nothing
    thr_hi = 12'd128; thr_lo = 12'd128;
    wait_cyc(128);
    chk("R3 equal hi", int'(flag_hi), 0);
    chk("R3 equal lo", int'(flag_lo), 0);

    // R7 then R2: lowered upper threshold applies two boundaries later
    thr_hi = 12'd100;
    wait_cyc(64);
    chk("R7 old threshold still used", int'(flag_hi), 0);
    wait_cyc(64);
    chk("R2 above threshold", int'(flag_hi), 1);
    chk("R2 no low side", int'(flag_lo), 0);

    // R4: sticky then cleared
    thr_hi = 12'd200;
    wait_cyc(128);
    chk("R4 sticky", int'(flag_hi), 1);
    pulse_clr();
    chk("R4 cleared", int'(flag_hi), 0);
    wait_cyc(127);
    chk("R4 stays clear", int'(flag_hi), 0);

    // R8: disabled holds flags, ignores violations, clear still works
    thr_hi = 12'd100;
    wait_cyc(128);
    chk("R2 set again", int'(flag_hi), 1);
    thr_lo = 12'd200;
    en = 1'b0;
    wait_cyc(256);
    chk("R8 hold hi", int'(flag_hi), 1);
    chk("R8 no new lo", int'(flag_lo), 0);
    pulse_clr();
    chk("R8 clear while idle", int'(flag_hi), 0);

    // R6: stopped monitored clock
    thr_hi = 12'd4095; thr_lo = 12'd10;
    pulse_clr();
    en = 1'b1;
    wait_cyc(160);
    chk("R6 running ok lo", int'(flag_lo), 0);
    mon_run = 1'b0;
    wait_cyc(320);
    chk("R6 stopped sets lo", int'(flag_lo), 1);
    chk("R6 stopped no hi", int'(flag_hi), 0);
    thr_lo = 12'd0;
    wait_cyc(128);
    pulse_clr();
    wait_cyc(256);
    chk("R6 zero lower threshold", int'(flag_lo), 0);
    en = 1'b0;
    mon_run = 1'b1;

    // R9: very fast clock saturates at 4095
    mon_half = 0.05; thr_hi = 12'd4095; thr_lo = 12'd4000;
    wait_cyc(8);
    pulse_clr();
    en = 1'b1;
    wait_cyc(224);
    chk("R9 saturated no lo", int'(flag_lo), 0);
    chk("R9 saturated no hi", int'(flag_hi), 0);
    thr_hi = 12'd4094;
    wait_cyc(128);
    chk("R9 saturated above 4094", int'(flag_hi), 1);
    en = 1'b0;
    mon_half = 2.0;

    // R1/R2/R3 random frequencies and thresholds
    for (int it = 0; it < 12; it++) begin
      real halves [6] = '{1.5, 2.0, 2.5, 3.0, 5.0, 8.0};
      real n;
      int  hi, lo;
      mon_half = halves[$urandom_range(0, 5)];
      n  = exp_count(mon_half);
      hi = pick_thr(n);
      lo = pick_thr(n);
      en = 1'b0;
      wait_cyc(8);
      pulse_clr();
      thr_hi = 12'(hi);
      thr_lo = 12'(lo);
      en = 1'b1;
      wait_cyc(224);
      chk("R2 random hi", int'(flag_hi), (n > real'(hi)) ? 1 : 0);
      chk("R3 random lo", int'(flag_lo), (n < real'(lo)) ? 1 : 0);
    end
    en = 1'b0;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_ref);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule